// File: doc/BRIEF.md
# Calendar Real-Time Clock with BCD Year

This block is a wall-clock timer that keeps the date and time as a packed calendar word (second, minute, hour, weekday, day of month, month) together with a four-digit year in BCD. A prescaler divides the core clock down to one tick per second. Once counting is switched on, each tick advances the calendar with full rollover: seconds into minutes, minutes into hours, hours into days, with month lengths that follow the month and the leap-year rule, months into years, and a decimal carry from the two-digit year into the century.

Software reaches the block through a simple word-addressed register port. It can read the running time and year, load new values into either, and program an alarm made of a time-word match and a year match. The alarm latches a sticky raw flag when both parts equal the running values. A mask bit routes that flag to the interrupt output, and a write to the clear register drops the flag again.

Top module: `rtc_cal_top`

## Requirements
- R1: After reset the time word reads 0x021E0000 (month 1, day 1, weekday 7 = Saturday, 00:00:00), the year reads 0x2000, the raw alarm flag reads 0 and `irq` is low. Time word fields: second [5:0], minute [11:6], hour [16:12], weekday [19:17] (1 = Sunday .. 7 = Saturday), day [24:20], month [28:25] (1..12). Year: two low digits as BCD in [7:0], century as BCD in [15:8].
- R2: The calendar advances only while control bit 26 (offset 0x0C) is 1. It then advances by exactly one second every TICKS_PER_SEC clock cycles. With the bit at 0, the time and year hold their values.
- R3: Seconds and minutes wrap from 59 to 0 and carry into the next field. Hours wrap from 23 to 0 and carry into the day.
- R4: The day wraps to 1 after day 30 in months 4, 6, 9 and 11, and after day 31 in the other months, except month 2. Month 2 ends after day 29 in a leap year and after day 28 otherwise. A year is a leap year when it is divisible by 4 and is not a century year, or when it is divisible by 400.
- R5: On every day rollover the weekday increments by one, and weekday 7 is followed by 1.
- R6: Month 12 rolls over to month 1 and increments the BCD year with a decimal carry (0x2009 to 0x2010, 0x2099 to 0x2100).
- R7: A write to the time load register (0x08) or the year load register (0x38) replaces the running value on the next cycle and restarts the prescaler. The next second then falls exactly TICKS_PER_SEC cycles after the write.
- R8: The raw alarm flag (offset 0x14, bit 0) sets in the cycle after the time word equals the time match (0x04) and the year equals the year match (0x34). It is not set if only the time word matches. Once set, it stays set until a write of 1 to bit 0 of the clear register (0x1C), and a new match overrides that clear.
- R9: `irq` and the masked status (0x18, bit 0) are high only while both the raw flag and the mask bit (0x10, bit 0) are set.
- R10: The time data, time match, time load, control, mask, raw, masked, year data, year match and year load registers sit at offsets 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18, 0x30, 0x34 and 0x38. The writable ones read back what was last written, and unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 6 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the register at `bus_addr` (combinational) |
| irq | output | 1 | Alarm interrupt, raw flag AND mask |

## Verification
The bound checker watches several behaviours on every cycle: the reset image, the hold while counting is off, the second-to-minute and Saturday-to-Sunday wraps, the year step at New Year, the load landing with a prescaler restart, and the setting, stickiness and masking of the raw flag. Month lengths, the leap and century rules and the decimal year carry can only be exposed by the bench's scenarios. The bench loads dates just before each boundary and steps them across one second, while its behavioural calendar model tracks the time word and the interrupt through every clock.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    typedef struct packed {
        logic [2:0] pad;
        logic [3:0] mon;
        logic [4:0] mday;
        logic [2:0] wday;
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } cal_time_t;

    localparam int ADDR_W   = 6;
    localparam int DATA_W   = 32;
    localparam int YEAR_W   = 16;
    localparam int RUN_BIT  = 26;

    localparam logic [ADDR_W-1:0] OFS_TIME   = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_TMATCH = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_TLOAD  = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_RAW    = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_MASKED = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_CLEAR  = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_YEAR   = 6'h30;
    localparam logic [ADDR_W-1:0] OFS_YMATCH = 6'h34;
    localparam logic [ADDR_W-1:0] OFS_YLOAD  = 6'h38;

    localparam cal_time_t RESET_TIME = '{pad: 3'd0, mon: 4'd1, mday: 5'd1,
                                         wday: 3'd7, hour: 5'd0, min: 6'd0,
                                         sec: 6'd0};
    localparam logic [YEAR_W-1:0] RESET_YEAR = 16'h2000;

    typedef enum logic [3:0] {
        SEL_TIME, SEL_TMATCH, SEL_TLOAD, SEL_CTRL, SEL_MASK, SEL_RAW,
        SEL_MASKED, SEL_CLEAR, SEL_YEAR, SEL_YMATCH, SEL_YLOAD, SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_TIME:   return SEL_TIME;
            OFS_TMATCH: return SEL_TMATCH;
            OFS_TLOAD:  return SEL_TLOAD;
            OFS_CTRL:   return SEL_CTRL;
            OFS_MASK:   return SEL_MASK;
            OFS_RAW:    return SEL_RAW;
            OFS_MASKED: return SEL_MASKED;
            OFS_CLEAR:  return SEL_CLEAR;
            OFS_YEAR:   return SEL_YEAR;
            OFS_YMATCH: return SEL_YMATCH;
            OFS_YLOAD:  return SEL_YLOAD;
            default:    return SEL_NONE;
        endcase
    endfunction

    // Two BCD digits to binary 0..99
    function automatic logic [6:0] bcd_pair_to_bin(input logic [7:0] b);
        return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
    endfunction

    // Leap rule on a BCD year: century years need century % 4 == 0
    function automatic logic leap_of_bcd(input logic [YEAR_W-1:0] y);
        logic [6:0] low2;
        logic [6:0] cent;
        low2 = bcd_pair_to_bin(y[7:0]);
        cent = bcd_pair_to_bin(y[15:8]);
        if (low2 == 7'd0)
            return cent[1:0] == 2'd0;
        return low2[1:0] == 2'd0;
    endfunction

    function automatic logic [4:0] month_length(input logic [3:0] mon,
                                                input logic leap);
        case (mon)
            4'd2:                    return leap ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
            default:                 return 5'd31;
        endcase
    endfunction

    // Four-digit BCD increment, 9999 wraps to 0000
    function automatic logic [YEAR_W-1:0] bcd_year_step(input logic [YEAR_W-1:0] y);
        logic [YEAR_W-1:0] r;
        logic              c;
        r = y;
        c = 1'b1;
        for (int i = 0; i < YEAR_W/4; i++) begin
            if (c) begin
                if (r[i*4 +: 4] >= 4'd9) begin
                    r[i*4 +: 4] = 4'd0;
                end else begin
                    r[i*4 +: 4] = r[i*4 +: 4] + 4'd1;
                    c = 1'b0;
                end
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/rtc_cal_prescaler.sv
module rtc_cal_prescaler #(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int CNT_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_SEC - 1);

    generate
        if (TICKS_PER_SEC <= 1) begin : g_direct
            assign tick = run && !restart;
        end else begin : g_count
            logic [CNT_W-1:0] cnt_q;
            always_ff @(posedge clk) begin
                if (rst || restart) begin
                    cnt_q <= '0;
                end else if (run) begin
                    if (cnt_q == LAST)
                        cnt_q <= '0;
                    else
                        cnt_q <= cnt_q + 1'b1;
                end
            end
            assign tick = run && !restart && (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/rtc_cal_counter.sv
module rtc_cal_counter
    import rtc_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              load_time,
    input  logic              load_year,
    input  cal_time_t         time_in,
    input  logic [YEAR_W-1:0] year_in,
    output cal_time_t         time_o,
    output logic [YEAR_W-1:0] year_o
);
    cal_time_t         time_q, time_nx;
    logic [YEAR_W-1:0] year_q, year_nx;
    logic [4:0]        last_day;

    always_comb begin
        time_nx  = time_q;
        year_nx  = year_q;
        last_day = month_length(time_q.mon, leap_of_bcd(year_q));
        if (time_q.sec >= 6'd59) begin
            time_nx.sec = 6'd0;
            if (time_q.min >= 6'd59) begin
                time_nx.min = 6'd0;
                if (time_q.hour >= 5'd23) begin
                    time_nx.hour = 5'd0;
                    time_nx.wday = (time_q.wday >= 3'd7) ? 3'd1 : time_q.wday + 3'd1;
                    if (time_q.mday >= last_day) begin
                        time_nx.mday = 5'd1;
                        if (time_q.mon >= 4'd12) begin
                            time_nx.mon = 4'd1;
                            year_nx     = bcd_year_step(year_q);
                        end else begin
                            time_nx.mon = time_q.mon + 4'd1;
                        end
                    end else begin
                        time_nx.mday = time_q.mday + 5'd1;
                    end
                end else begin
                    time_nx.hour = time_q.hour + 5'd1;
                end
            end else begin
                time_nx.min = time_q.min + 6'd1;
            end
        end else begin
            time_nx.sec = time_q.sec + 6'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            time_q <= RESET_TIME;
            year_q <= RESET_YEAR;
        end else begin
            if (load_time) begin
                time_q     <= time_in;
                time_q.pad <= 3'd0;
            end else if (tick) begin
                time_q <= time_nx;
            end
            if (load_year)
                year_q <= year_in;
            else if (tick)
                year_q <= year_nx;
        end
    end

    assign time_o = time_q;
    assign year_o = year_q;
endmodule

// File: rtl/rtc_cal_alarm.sv
module rtc_cal_alarm
    import rtc_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cal_time_t         time_now,
    input  logic [YEAR_W-1:0] year_now,
    input  logic              wr_tmatch,
    input  logic              wr_ymatch,
    input  logic              wr_mask,
    input  logic              wr_clear,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] tmatch_o,
    output logic [YEAR_W-1:0] ymatch_o,
    output logic              mask_o,
    output logic              raw_o
);
    logic [DATA_W-1:0] tmatch_q;
    logic [YEAR_W-1:0] ymatch_q;
    logic              mask_q, raw_q, hit, drop;

    assign hit  = (DATA_W'(time_now) == tmatch_q) && (year_now == ymatch_q);
    assign drop = wr_clear && wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            tmatch_q <= '0;
            ymatch_q <= '0;
            mask_q   <= 1'b0;
            raw_q    <= 1'b0;
        end else begin
            if (wr_tmatch) tmatch_q <= wdata;
            if (wr_ymatch) ymatch_q <= wdata[YEAR_W-1:0];
            if (wr_mask)   mask_q   <= wdata[0];
            raw_q <= (raw_q && !drop) || hit;
        end
    end

    assign tmatch_o = tmatch_q;
    assign ymatch_o = ymatch_q;
    assign mask_o   = mask_q;
    assign raw_o    = raw_q;
endmodule

// File: rtl/rtc_cal_top.sv
module rtc_cal_top
    import rtc_cal_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic [5:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);
    reg_sel_e          sel;
    logic              wr_tload, wr_yload, wr_ctrl, load_any, tick, run_q;
    logic [DATA_W-1:0] tload_q;
    logic [YEAR_W-1:0] yload_q;
    cal_time_t         time_q;
    logic [YEAR_W-1:0] year_q;
    logic [DATA_W-1:0] tmatch_q;
    logic [YEAR_W-1:0] ymatch_q;
    logic              mask_q, raw_q, clr_wr;

    assign sel      = decode_offset(bus_addr);
    assign wr_tload = bus_wr && (sel == SEL_TLOAD);
    assign wr_yload = bus_wr && (sel == SEL_YLOAD);
    assign wr_ctrl  = bus_wr && (sel == SEL_CTRL);
    assign clr_wr   = bus_wr && (sel == SEL_CLEAR);
    assign load_any = wr_tload || wr_yload;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= 1'b0;
            tload_q <= '0;
            yload_q <= '0;
        end else begin
            if (wr_ctrl)  run_q   <= bus_wdata[RUN_BIT];
            if (wr_tload) tload_q <= bus_wdata;
            if (wr_yload) yload_q <= bus_wdata[YEAR_W-1:0];
        end
    end

    rtc_cal_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .run     (run_q),
        .restart (load_any),
        .tick    (tick)
    );

    rtc_cal_counter u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .load_time (wr_tload),
        .load_year (wr_yload),
        .time_in   (cal_time_t'(bus_wdata)),
        .year_in   (bus_wdata[YEAR_W-1:0]),
        .time_o    (time_q),
        .year_o    (year_q)
    );

    rtc_cal_alarm u_alarm (
        .clk       (clk),
        .rst       (rst),
        .time_now  (time_q),
        .year_now  (year_q),
        .wr_tmatch (bus_wr && (sel == SEL_TMATCH)),
        .wr_ymatch (bus_wr && (sel == SEL_YMATCH)),
        .wr_mask   (bus_wr && (sel == SEL_MASK)),
        .wr_clear  (clr_wr),
        .wdata     (bus_wdata),
        .tmatch_o  (tmatch_q),
        .ymatch_o  (ymatch_q),
        .mask_o    (mask_q),
        .raw_o     (raw_q)
    );

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_TIME:   bus_rdata = DATA_W'(time_q);
            SEL_TMATCH: bus_rdata = tmatch_q;
            SEL_TLOAD:  bus_rdata = tload_q;
            SEL_CTRL:   bus_rdata[RUN_BIT] = run_q;
            SEL_MASK:   bus_rdata[0] = mask_q;
            SEL_RAW:    bus_rdata[0] = raw_q;
            SEL_MASKED: bus_rdata[0] = raw_q && mask_q;
            SEL_YEAR:   bus_rdata = DATA_W'(year_q);
            SEL_YMATCH: bus_rdata = DATA_W'(ymatch_q);
            SEL_YLOAD:  bus_rdata = DATA_W'(yload_q);
            default:    bus_rdata = '0;
        endcase
    end

    assign irq = raw_q && mask_q;
endmodule

// File: rtl/rtc_cal_checker.sv
module rtc_cal_checker #(
    parameter int TICKS = 32768
) (
    input logic        clk,
    input logic        rst,
    input logic        run,
    input logic        tick,
    input logic        load_any,
    input logic        load_time,
    input logic        clr_wr,
    input logic [31:0] wdata,
    input logic [31:0] time_w,
    input logic [15:0] year_w,
    input logic [31:0] tmatch,
    input logic [15:0] ymatch,
    input logic        raw,
    input logic        irq
);
    p_reset_image_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (time_w == 32'h021E0000 && year_w == 16'h2000 && !raw && !irq));

    p_hold_stopped_r2: assert property (@(posedge clk) disable iff (rst)
        (!run && !load_any) |=> ($stable(time_w) && $stable(year_w)));

    p_sec_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && time_w[5:0] == 6'd59) |=> (time_w[5:0] == 6'd0));

    p_wday_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && time_w[19:17] == 3'd7 && time_w[16:12] == 5'd23 &&
         time_w[11:6] == 6'd59 && time_w[5:0] == 6'd59) |=> (time_w[19:17] == 3'd1));

    p_new_year_r6: assert property (@(posedge clk) disable iff (rst)
        (tick && time_w[28:25] == 4'd12 && time_w[24:20] == 5'd31 &&
         time_w[16:12] == 5'd23 && time_w[11:6] == 6'd59 && time_w[5:0] == 6'd59)
        |=> (time_w[28:25] == 4'd1 && year_w != $past(year_w)));

    p_load_lands_r7: assert property (@(posedge clk) disable iff (rst)
        load_time |=> (time_w[28:0] == $past(wdata[28:0])));

    p_restart_r7: assert property (@(posedge clk) disable iff (rst)
        (load_any && TICKS > 1) |=> !tick);

    p_match_sets_r8: assert property (@(posedge clk) disable iff (rst)
        (time_w == tmatch && year_w == ymatch) |=> raw);

    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (raw && !(clr_wr && wdata[0])) |=> raw);

    p_irq_needs_raw_r9: assert property (@(posedge clk) disable iff (rst)
        !raw |-> !irq);
endmodule

bind rtc_cal_top rtc_cal_checker #(.TICKS(TICKS_PER_SEC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .run       (run_q),
    .tick      (tick),
    .load_any  (load_any),
    .load_time (wr_tload),
    .clr_wr    (clr_wr),
    .wdata     (bus_wdata),
    .time_w    (32'(time_q)),
    .year_w    (year_q),
    .tmatch    (tmatch_q),
    .ymatch    (ymatch_q),
    .raw       (raw_q),
    .irq       (irq)
);

// File: tb/sim_rtc_cal_top.sv
module sim_rtc_cal_top;
    localparam int T = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = 6'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    rtc_cal_top #(.TICKS_PER_SEC(T)) u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [31:0] pk(int mon, int mday, int wday, int hr, int mn, int sc);
        return (32'(mon) << 25) | (32'(mday) << 20) | (32'(wday) << 17) |
               (32'(hr) << 12) | (32'(mn) << 6) | 32'(sc);
    endfunction

    function automatic logic [15:0] to_bcd(int y);
        return {4'((y / 1000) % 10), 4'((y / 100) % 10), 4'((y / 10) % 10), 4'(y % 10)};
    endfunction

    function automatic int from_bcd(logic [15:0] b);
        return int'(b[15:12]) * 1000 + int'(b[11:8]) * 100 + int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic int mlen(int mon, int y);
        bit lp;
        lp = ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
        if (mon == 2) return lp ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    // Behavioural reference calendar
    int m_sec, m_min, m_hour, m_wday, m_mday, m_mon, m_year, m_pc;
    bit m_run, m_raw, m_mask, m_hit, m_clr, m_tick, m_ld;
    logic [31:0] m_tmatch;
    logic [15:0] m_ymatch;

    task automatic m_advance();
        m_sec++;
        if (m_sec >= 60) begin
            m_sec = 0; m_min++;
            if (m_min >= 60) begin
                m_min = 0; m_hour++;
                if (m_hour >= 24) begin
                    m_hour = 0;
                    m_wday = (m_wday >= 7) ? 1 : m_wday + 1;
                    m_mday++;
                    if (m_mday > mlen(m_mon, m_year)) begin
                        m_mday = 1; m_mon++;
                        if (m_mon > 12) begin
                            m_mon = 1;
                            m_year = (m_year + 1) % 10000;
                        end
                    end
                end
            end
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_sec = 0; m_min = 0; m_hour = 0; m_wday = 7; m_mday = 1; m_mon = 1;
            m_year = 2000; m_pc = 0; m_run = 0; m_raw = 0; m_mask = 0;
            m_tmatch = '0; m_ymatch = '0;
        end else begin
            m_hit = (pk(m_mon, m_mday, m_wday, m_hour, m_min, m_sec) == m_tmatch) &&
                    (to_bcd(m_year) == m_ymatch);
            m_clr = bus_wr && bus_addr == 6'h1C && bus_wdata[0];
            m_ld  = bus_wr && (bus_addr == 6'h08 || bus_addr == 6'h38);
            m_tick = 0;
            if (m_ld) m_pc = 0;
            else if (m_run) begin
                if (m_pc == T - 1) begin m_pc = 0; m_tick = 1; end
                else m_pc++;
            end
            if (m_tick) m_advance();
            if (bus_wr) begin
                case (bus_addr)
                    6'h08: begin
                        m_sec = int'(bus_wdata[5:0]);   m_min = int'(bus_wdata[11:6]);
                        m_hour = int'(bus_wdata[16:12]); m_wday = int'(bus_wdata[19:17]);
                        m_mday = int'(bus_wdata[24:20]); m_mon = int'(bus_wdata[28:25]);
                    end
                    6'h38: m_year = from_bcd(bus_wdata[15:0]);
                    6'h04: m_tmatch = bus_wdata;
                    6'h34: m_ymatch = bus_wdata[15:0];
                    6'h0C: m_run = bus_wdata[26];
                    6'h10: m_mask = bus_wdata[0];
                    default: ;
                endcase
            end
            m_raw = (m_raw && !m_clr) || m_hit;
        end
    end

    // Per-cycle comparison against the model
    always begin
        @(negedge clk);
        #3;
        if (!rst) begin
            checks++;
            if (irq !== (m_raw && m_mask)) begin
                errors++;
                $display("FAIL R9 model irq: got %0b exp %0b", irq, m_raw && m_mask);
            end
            if (!bus_wr && bus_addr == 6'h00) begin
                checks++;
                if (bus_rdata !== pk(m_mon, m_mday, m_wday, m_hour, m_min, m_sec)) begin
                    errors++;
                    $display("FAIL R2 model time: got %h exp %h", bus_rdata,
                             pk(m_mon, m_mday, m_wday, m_hour, m_min, m_sec));
                end
            end
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 6'h00; bus_wdata = '0;
    endtask

    task automatic rd_check(input logic [5:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        checks++;
        if (bus_rdata !== exp) begin
            errors++;
            $display("FAIL %s: offset %h got %h exp %h", tag, a, bus_rdata, exp);
        end
        bus_addr = 6'h00;
    endtask

    task automatic bit_check(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0b exp %0b", tag, got, exp);
        end
    endtask

    task automatic load_step(input logic [15:0] y, input logic [31:0] t,
                             input logic [31:0] exp_t, input logic [15:0] exp_y,
                             input string tag);
        wr(6'h38, {16'h0, y});
        wr(6'h08, t);
        repeat (T - 1) @(posedge clk);
        rd_check(6'h00, t, "R7 no step before a full second");
        @(posedge clk);
        rd_check(6'h00, exp_t, tag);
        rd_check(6'h30, {16'h0, exp_y}, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rd_check(6'h00, 32'h021E0000, "R1 reset time");
        rd_check(6'h30, 32'h00002000, "R1 reset year");
        rd_check(6'h14, 32'h0, "R1 reset raw");
        bit_check(irq, 1'b0, "R1 reset irq");

        repeat (3 * T) @(posedge clk);
        rd_check(6'h00, 32'h021E0000, "R2 held while stopped");
        rd_check(6'h30, 32'h00002000, "R2 year held while stopped");

        wr(6'h0C, 32'h04000000);
        rd_check(6'h0C, 32'h04000000, "R10 control readback");
        repeat (T * 2 + 1) @(posedge clk);
        rd_check(6'h00, pk(1, 1, 7, 0, 0, 2), "R2 two seconds counted");

        load_step(16'h2024, pk(6, 15, 2, 10, 20, 59), pk(6, 15, 2, 10, 21, 0), 16'h2024, "R3 second wrap");
        load_step(16'h2024, pk(6, 15, 2, 10, 59, 59), pk(6, 15, 2, 11, 0, 0), 16'h2024, "R3 minute wrap");
        load_step(16'h2000, pk(2, 28, 2, 23, 59, 59), pk(2, 29, 3, 0, 0, 0), 16'h2000, "R4 leap century 2000");
        load_step(16'h2000, pk(2, 29, 3, 23, 59, 59), pk(3, 1, 4, 0, 0, 0), 16'h2000, "R4 end of leap Feb");
        load_step(16'h2100, pk(2, 28, 1, 23, 59, 59), pk(3, 1, 2, 0, 0, 0), 16'h2100, "R4 non-leap century 2100");
        load_step(16'h2023, pk(2, 28, 3, 23, 59, 59), pk(3, 1, 4, 0, 0, 0), 16'h2023, "R4 ordinary Feb");
        load_step(16'h2024, pk(2, 29, 5, 23, 59, 59), pk(3, 1, 6, 0, 0, 0), 16'h2024, "R4 leap 2024");
        load_step(16'h2024, pk(4, 30, 7, 23, 59, 59), pk(5, 1, 1, 0, 0, 0), 16'h2024, "R5 Saturday to Sunday");
        load_step(16'h2024, pk(5, 30, 3, 23, 59, 59), pk(5, 31, 4, 0, 0, 0), 16'h2024, "R4 31-day month");
        load_step(16'h2009, pk(12, 31, 3, 23, 59, 59), pk(1, 1, 4, 0, 0, 0), 16'h2010, "R6 year carry 2009");
        load_step(16'h2099, pk(12, 31, 5, 23, 59, 59), pk(1, 1, 6, 0, 0, 0), 16'h2100, "R6 century carry 2099");
        rd_check(6'h08, pk(12, 31, 5, 23, 59, 59), "R10 time load readback");
        rd_check(6'h38, 32'h00002099, "R10 year load readback");

        // Alarm
        wr(6'h10, 32'h1);
        wr(6'h04, pk(7, 4, 3, 12, 0, 2));
        wr(6'h34, 32'h00002030);
        rd_check(6'h04, pk(7, 4, 3, 12, 0, 2), "R10 match readback");
        rd_check(6'h34, 32'h00002030, "R10 year match readback");
        rd_check(6'h10, 32'h1, "R10 mask readback");
        rd_check(6'h20, 32'h0, "R10 unmapped offset");
        wr(6'h38, 32'h00002030);
        wr(6'h08, pk(7, 4, 3, 12, 0, 0));
        rd_check(6'h14, 32'h0, "R8 raw clear before match");
        repeat (3 * T + 1) @(posedge clk);
        rd_check(6'h14, 32'h1, "R8 raw set on match");
        rd_check(6'h18, 32'h1, "R9 masked status");
        bit_check(irq, 1'b1, "R9 irq asserted");
        repeat (2 * T) @(posedge clk);
        rd_check(6'h14, 32'h1, "R8 raw sticky");
        wr(6'h1C, 32'h1);
        rd_check(6'h14, 32'h0, "R8 raw cleared");
        bit_check(irq, 1'b0, "R9 irq dropped");

        wr(6'h34, 32'h00002031);
        wr(6'h08, pk(7, 4, 3, 12, 0, 0));
        repeat (4 * T) @(posedge clk);
        rd_check(6'h14, 32'h0, "R8 no set on year mismatch");

        wr(6'h34, 32'h00002030);
        wr(6'h10, 32'h0);
        wr(6'h08, pk(7, 4, 3, 12, 0, 0));
        repeat (3 * T + 1) @(posedge clk);
        rd_check(6'h14, 32'h1, "R8 raw set with mask off");
        rd_check(6'h18, 32'h0, "R9 masked status off");
        bit_check(irq, 1'b0, "R9 irq masked");

        wr(6'h0C, 32'h0);
        rd_check(6'h0C, 32'h0, "R10 control cleared");
        repeat (3 * T) @(posedge clk);
        rd_check(6'h00, pk(m_mon, m_mday, m_wday, m_hour, m_min, m_sec), "R2 stopped again");

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule